// File: doc/BRIEF.md
# Configuration Page Download Controller

This block fills the working register file from a paged nonvolatile configuration array. The array holds 512 bytes as 16 pages of 32 bytes. Only the low seven pages (0 to 6) carry register settings and are copied. Page 7 is reserved and pages 8 to 15 hold user data, so neither is ever read. A nonvolatile byte sits at the register's own address with a fixed high byte of `0xF8`. The register address is therefore the low byte of the array address.

A download starts without help once the supply is reported valid after reset. Software can start another one by writing a one to bit 0 of the control location `0xD8`. That trigger flag clears itself when the copy finishes. Bytes move one at a time in ascending order. Each byte uses a read handshake on the array port and then a write handshake on the register port. A `busy` flag and a `bus_hold` flag let the bus slave refuse accesses while the register contents are incomplete.

The controller has five states:
- **WAIT_PWR**: the state after reset.
- **IDLE**: waiting for a software trigger.
- **READ**: a nonvolatile read request is outstanding.
- **WRITE**: a register write request is outstanding.
- **DONE**: a one-cycle completion state.

It moves between them as follows:
- **WAIT_PWR → READ** when `supply_ok` is high.
- **IDLE → READ** on an accepted trigger write.
- **READ → WRITE** on `nv_rd_ack`.
- **WRITE → READ** on `rf_wr_ack` when more bytes remain.
- **WRITE → DONE** on `rf_wr_ack` for the last byte.
- **DONE → IDLE** always.

Top module: `nvdl_ctrl`

## Requirements
- R1: After reset the outputs are as follows: `busy`, `done`, `nv_rd_req`, `rf_wr_req` and `trig_flag` are 0, and `bus_hold` is 1. No read request appears while `supply_ok` stays low.
- R2: When `supply_ok` goes high, the power-up download starts. Its first read request is at array address `0xF800`.
- R3: A download makes exactly 224 transfers. Read k (k = 0..223) uses array address `{0xF8, k}`. The write that follows uses register address `k` and carries the byte returned by that read. Transfers run in ascending k.
- R4: No read touches array addresses `0xF8E0` to `0xF9FF`. No write touches register addresses `0xE0` to `0xFF`.
- R5: At most one request is raised at a time. A raised request holds its address, and for writes its data, stable until it is acknowledged.
- R6: `done` is high for exactly one cycle after the last write is acknowledged. `busy` is low in that cycle and was high in the cycle before.
- R7: `bus_hold` is 1 whenever `busy` is 1. It is also 1 from reset until the cycle after the power-up `done` pulse, and 0 afterwards while idle.
- R8: A control write of data bit 0 = 1 to address `0xD8` while idle does two things. It sets `trig_flag` in the next cycle and starts a download with `busy` high in that same cycle. `trig_flag` returns to 0 in the cycle after `done`.
- R9: A trigger write made during a download or before power-up is ignored. `trig_flag` stays 0 and no further download follows.
- R10: Some control writes are ignored: any write to an address other than `0xD8`, and any write to `0xD8` with data bit 0 = 0. Each such write leaves `trig_flag` at 0 and raises no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Supply valid; starts the power-up download |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_addr | input | 8 | Control register write address |
| ctl_wdata | input | 8 | Control register write data |
| nv_rd_req | output | 1 | Nonvolatile read request, held until acknowledged |
| nv_rd_addr | output | 16 | Nonvolatile byte address |
| nv_rd_ack | input | 1 | Read acknowledge, with data valid |
| nv_rd_data | input | 8 | Read data |
| rf_wr_req | output | 1 | Register write request, held until acknowledged |
| rf_wr_addr | output | 8 | Register write address |
| rf_wr_data | output | 8 | Register write data |
| rf_wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | Download in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_hold | output | 1 | Bus access must be refused |
| trig_flag | output | 1 | Software trigger bit, self-clearing |

## Verification
The assertions watch properties that hold on every cycle:
- At most one request is raised at a time (R5).
- A request holds its address and data while it waits for an acknowledge (R5).
- Read addresses stay inside the seven configuration pages (R4).
- `done` is a single pulse that coincides with `busy` falling (R6).
- `bus_hold` covers `busy` (R7).
- `trig_flag` clears after `done` (R8).

Only the bench scenarios can show the full copy: the right byte reaching every register in ascending order, and the upper registers left untouched. They also show three further behaviours. A trigger during a download produces no second run. Writes to the wrong address or with the wrong bit are ignored. Downloads behave the same whether the handshake latency is short or long.

// File: rtl/nvdl_pkg.sv
package nvdl_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_PWR = 3'd0,
        ST_IDLE     = 3'd1,
        ST_READ     = 3'd2,
        ST_WRITE    = 3'd3,
        ST_DONE     = 3'd4
    } dl_state_t;

endpackage

// File: rtl/nvdl_addr_gen.sv
module nvdl_addr_gen #(
    parameter int ADDR_W     = 16,
    parameter int RADDR_W    = 8,
    parameter int PAGE_BYTES = 32,
    parameter int NUM_PAGES  = 7,
    parameter int FIRST_PAGE = 0,
    parameter logic [ADDR_W-RADDR_W-1:0] NV_PREFIX = 8'hF8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               adv,
    output logic               last,
    output logic [ADDR_W-1:0]  nv_addr,
    output logic [RADDR_W-1:0] rf_addr
);

    localparam int TOTAL = PAGE_BYTES * NUM_PAGES;
    localparam int CW    = (TOTAL > 1) ? $clog2(TOTAL) : 1;
    localparam int BASE  = FIRST_PAGE * PAGE_BYTES;

    logic [CW-1:0]      idx_q;
    logic [RADDR_W-1:0] offs;

    // Byte index within the downloaded range, ascending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr) begin
            idx_q <= '0;
        end else if (adv) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign last = (idx_q == CW'(TOTAL - 1));

    // Fit the index to the register address width.
    generate
        if (CW >= RADDR_W) begin : g_trunc
            assign offs = idx_q[RADDR_W-1:0];
        end else begin : g_pad
            assign offs = {{(RADDR_W-CW){1'b0}}, idx_q};
        end
    endgenerate

    // Register address is the low part; the array adds a fixed high prefix.
    assign rf_addr = RADDR_W'(BASE) + offs;
    assign nv_addr = {NV_PREFIX, rf_addr};

endmodule

// File: rtl/nvdl_trig_reg.sv
module nvdl_trig_reg #(
    parameter int RADDR_W = 8,
    parameter logic [RADDR_W-1:0] TRIG_ADDR = 8'hD8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RADDR_W-1:0] wr_addr,
    input  logic               wr_bit,
    input  logic               accept,
    input  logic               clear,
    output logic               start,
    output logic               flag
);

    logic flag_q;

    // A trigger counts only when the controller can take it.
    assign start = wr_en && (wr_addr == TRIG_ADDR) && wr_bit && accept;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (clear) begin
            flag_q <= 1'b0;
        end else if (start) begin
            flag_q <= 1'b1;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/nvdl_fsm.sv
module nvdl_fsm
    import nvdl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              sw_start,
    input  logic              nv_rd_ack,
    input  logic [DATA_W-1:0] nv_rd_data,
    input  logic              rf_wr_ack,
    input  logic              last,
    output dl_state_t         state,
    output logic              nv_rd_req,
    output logic              rf_wr_req,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              boot_done,
    output logic              cnt_clr,
    output logic              cnt_adv,
    output logic              idle
);

    dl_state_t         state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              boot_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_PWR: if (supply_ok) state_d = ST_READ;
            ST_IDLE:     if (sw_start)  state_d = ST_READ;
            ST_READ:     if (nv_rd_ack) state_d = ST_WRITE;
            ST_WRITE: begin
                if (rf_wr_ack) state_d = last ? ST_DONE : ST_READ;
            end
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_WAIT_PWR;
        endcase
    end

    // State register with the captured byte and the power-up completion bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_PWR;
            data_q  <= '0;
            boot_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_READ) && nv_rd_ack) begin
                data_q <= nv_rd_data;
            end
            if (state_q == ST_DONE) begin
                boot_q <= 1'b1;
            end
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        nv_rd_req = 1'b0;
        rf_wr_req = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        cnt_adv   = 1'b0;
        idle      = 1'b0;
        unique case (state_q)
            ST_WAIT_PWR: begin
            end
            ST_IDLE: begin
                idle = 1'b1;
            end
            ST_READ: begin
                nv_rd_req = 1'b1;
                busy      = 1'b1;
            end
            ST_WRITE: begin
                rf_wr_req = 1'b1;
                busy      = 1'b1;
                cnt_adv   = rf_wr_ack && !last;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign cnt_clr   = !busy;
    assign wr_data   = data_q;
    assign boot_done = boot_q;
    assign state     = state_q;

endmodule

// File: rtl/nvdl_ctrl.sv
module nvdl_ctrl
    import nvdl_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int RADDR_W    = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int NUM_PAGES  = 7,
    parameter int FIRST_PAGE = 0,
    parameter logic [ADDR_W-RADDR_W-1:0] NV_PREFIX = 8'hF8,
    parameter logic [RADDR_W-1:0] TRIG_ADDR = 8'hD8,
    parameter int TRIG_BIT   = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               supply_ok,
    input  logic               ctl_wr,
    input  logic [RADDR_W-1:0] ctl_addr,
    input  logic [DATA_W-1:0]  ctl_wdata,
    output logic               nv_rd_req,
    output logic [ADDR_W-1:0]  nv_rd_addr,
    input  logic               nv_rd_ack,
    input  logic [DATA_W-1:0]  nv_rd_data,
    output logic               rf_wr_req,
    output logic [RADDR_W-1:0] rf_wr_addr,
    output logic [DATA_W-1:0]  rf_wr_data,
    input  logic               rf_wr_ack,
    output logic               busy,
    output logic               done,
    output logic               bus_hold,
    output logic               trig_flag
);

    dl_state_t state;
    logic      last, cnt_clr, cnt_adv, idle, sw_start, boot_done;
    logic      unused_ctl;

    assign unused_ctl = ^ctl_wdata;

    nvdl_addr_gen #(
        .ADDR_W     (ADDR_W),
        .RADDR_W    (RADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .NUM_PAGES  (NUM_PAGES),
        .FIRST_PAGE (FIRST_PAGE),
        .NV_PREFIX  (NV_PREFIX)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .adv     (cnt_adv),
        .last    (last),
        .nv_addr (nv_rd_addr),
        .rf_addr (rf_wr_addr)
    );

    nvdl_trig_reg #(
        .RADDR_W   (RADDR_W),
        .TRIG_ADDR (TRIG_ADDR)
    ) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr),
        .wr_addr (ctl_addr),
        .wr_bit  (ctl_wdata[TRIG_BIT]),
        .accept  (idle),
        .clear   (done),
        .start   (sw_start),
        .flag    (trig_flag)
    );

    nvdl_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok  (supply_ok),
        .sw_start   (sw_start),
        .nv_rd_ack  (nv_rd_ack),
        .nv_rd_data (nv_rd_data),
        .rf_wr_ack  (rf_wr_ack),
        .last       (last),
        .state      (state),
        .nv_rd_req  (nv_rd_req),
        .rf_wr_req  (rf_wr_req),
        .wr_data    (rf_wr_data),
        .busy       (busy),
        .done       (done),
        .boot_done  (boot_done),
        .cnt_clr    (cnt_clr),
        .cnt_adv    (cnt_adv),
        .idle       (idle)
    );

    // Bus stays locked until the first download completes and during any run.
    assign bus_hold = busy || !boot_done;

endmodule

// File: rtl/nvdl_ctrl_chk.sv
module nvdl_ctrl_chk #(
    parameter int ADDR_W     = 16,
    parameter int RADDR_W    = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int NUM_PAGES  = 7,
    parameter int FIRST_PAGE = 0,
    parameter logic [ADDR_W-RADDR_W-1:0] NV_PREFIX = 8'hF8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               nv_rd_req,
    input logic [ADDR_W-1:0]  nv_rd_addr,
    input logic               nv_rd_ack,
    input logic               rf_wr_req,
    input logic [RADDR_W-1:0] rf_wr_addr,
    input logic [DATA_W-1:0]  rf_wr_data,
    input logic               rf_wr_ack,
    input logic               busy,
    input logic               done,
    input logic               bus_hold,
    input logic               trig_flag
);

    localparam int LO = FIRST_PAGE * PAGE_BYTES;
    localparam int HI = LO + PAGE_BYTES * NUM_PAGES;

    // R5: never both requests at once
    p_single_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(nv_rd_req && rf_wr_req));

    // R5: a waiting read keeps its address
    p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_rd_req && !nv_rd_ack) |=> (nv_rd_req && $stable(nv_rd_addr)));

    // R5: a waiting write keeps address and data
    p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_req && !rf_wr_ack) |=> (rf_wr_req && $stable(rf_wr_addr) && $stable(rf_wr_data)));

    // R4: reads stay inside the configuration pages
    p_rd_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nv_rd_req |-> ((nv_rd_addr[ADDR_W-1:RADDR_W] == NV_PREFIX)
                       && (int'(nv_rd_addr[RADDR_W-1:0]) >= LO)
                       && (int'(nv_rd_addr[RADDR_W-1:0]) < HI)));

    // R4: writes stay inside the configuration registers
    p_wr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_req |-> (int'(rf_wr_addr) < HI));

    // R6: done is one cycle long
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: busy falls in the done cycle
    p_done_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R7: bus held whenever busy
    p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> bus_hold);

    // R8: trigger flag self-clears
    p_trig_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !trig_flag);

endmodule

bind nvdl_ctrl nvdl_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .RADDR_W    (RADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES),
    .NUM_PAGES  (NUM_PAGES),
    .FIRST_PAGE (FIRST_PAGE),
    .NV_PREFIX  (NV_PREFIX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nv_rd_req  (nv_rd_req),
    .nv_rd_addr (nv_rd_addr),
    .nv_rd_ack  (nv_rd_ack),
    .rf_wr_req  (rf_wr_req),
    .rf_wr_addr (rf_wr_addr),
    .rf_wr_data (rf_wr_data),
    .rf_wr_ack  (rf_wr_ack),
    .busy       (busy),
    .done       (done),
    .bus_hold   (bus_hold),
    .trig_flag  (trig_flag)
);

// File: tb/sim_nvdl_ctrl.sv
`timescale 1ns/1ps
module sim_nvdl_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        supply_ok = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_addr = '0;
    logic [7:0]  ctl_wdata = '0;
    logic        nv_rd_req, rf_wr_req, busy, done, bus_hold, trig_flag;
    logic [15:0] nv_rd_addr;
    logic        nv_rd_ack = 1'b0;
    logic [7:0]  nv_rd_data = '0;
    logic [7:0]  rf_wr_addr, rf_wr_data;
    logic        rf_wr_ack = 1'b0;

    int total = 0;
    int bad = 0;
    int lat = 1;
    logic [7:0] seed = 8'h3C;
    logic [7:0] rf_mem [256];
    int rd_cnt = 0, wr_cnt = 0, order_err = 0, range_err = 0;
    int done_cnt = 0, done_err = 0, hold_err = 0;
    int first_rd = -1;
    int rc = 0, wc = 0;
    logic prev_done = 1'b0, prev_busy = 1'b0;

    always #5 clk = ~clk;

    nvdl_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
        .nv_rd_req(nv_rd_req), .nv_rd_addr(nv_rd_addr),
        .nv_rd_ack(nv_rd_ack), .nv_rd_data(nv_rd_data),
        .rf_wr_req(rf_wr_req), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
        .rf_wr_ack(rf_wr_ack), .busy(busy), .done(done),
        .bus_hold(bus_hold), .trig_flag(trig_flag)
    );

    function automatic logic [7:0] nv_val(input logic [15:0] a, input logic [7:0] s);
        return (a[7:0] * 8'd7) ^ s ^ a[15:8];
    endfunction

    // Array and register-file models, plus monitors, all at the falling edge.
    always @(negedge clk) begin
        if (nv_rd_ack) begin
            nv_rd_ack <= 1'b0; rc = 0;
        end else if (nv_rd_req) begin
            if (rc >= lat) begin
                nv_rd_ack  <= 1'b1;
                nv_rd_data <= nv_val(nv_rd_addr, seed);
                if (first_rd < 0) first_rd = nv_rd_addr;
                if (nv_rd_addr != {8'hF8, 8'(rd_cnt)}) order_err++;
                if (nv_rd_addr < 16'hF800 || nv_rd_addr > 16'hF8DF) range_err++;
                rd_cnt++;
            end else rc++;
        end
        if (rf_wr_ack) begin
            rf_wr_ack <= 1'b0; wc = 0;
        end else if (rf_wr_req) begin
            if (wc >= lat) begin
                rf_wr_ack <= 1'b1;
                rf_mem[rf_wr_addr] = rf_wr_data;
                if (rf_wr_addr != 8'(wr_cnt)) order_err++;
                if (rf_wr_addr > 8'hDF) range_err++;
                wr_cnt++;
            end else wc++;
        end
        if (done) begin
            done_cnt++;
            if (busy || prev_done || !prev_busy) done_err++;
        end
        if (busy && !bus_hold) hold_err++;
        prev_done = done;
        prev_busy = busy;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic prep(input logic [7:0] s, input int l);
        seed = s; lat = l;
        for (int i = 0; i < 256; i++) rf_mem[i] = 8'hEE;
        rd_cnt = 0; wr_cnt = 0; order_err = 0; range_err = 0;
        done_cnt = 0; done_err = 0; hold_err = 0; first_rd = -1;
    endtask

    task automatic ctl_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_addr = a; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (done_cnt == 0 && n < 20000) begin
            @(negedge clk); n++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic check_copy(input string tag);
        int mism = 0, touched = 0;
        for (int i = 0; i < 224; i++)
            if (rf_mem[i] != nv_val({8'hF8, 8'(i)}, seed)) mism++;
        for (int i = 224; i < 256; i++)
            if (rf_mem[i] != 8'hEE) touched++;
        chk(mism == 0, "R3", {tag, " register contents"}, mism, 0);
        chk(rd_cnt == 224 && wr_cnt == 224, "R3", {tag, " transfer count"}, wr_cnt, 224);
        chk(order_err == 0, "R3", {tag, " ascending order"}, order_err, 0);
        chk(touched == 0 && range_err == 0, "R4", {tag, " upper pages untouched"},
            touched + range_err, 0);
        chk(done_cnt == 1 && done_err == 0, "R6", {tag, " done pulse"}, done_err, 0);
        chk(hold_err == 0, "R7", {tag, " bus_hold during busy"}, hold_err, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(!busy && !done && !trig_flag, "R1", "idle outputs", {busy, done, trig_flag}, 0);
        chk(bus_hold == 1'b1, "R1", "bus_hold at reset", bus_hold, 1);
        chk(!nv_rd_req && !rf_wr_req && rd_cnt == 0, "R1", "no request without supply", rd_cnt, 0);
    endtask

    task automatic t_powerup();
        prep(8'h3C, 1);
        @(negedge clk);
        supply_ok = 1'b1;
        repeat (12) @(negedge clk);
        chk(busy && bus_hold, "R7", "hold while downloading", bus_hold, 1);
        ctl_write(8'hD8, 8'h01);    // R9: ignored during download
        @(negedge clk);
        chk(trig_flag == 1'b0, "R9", "trigger while busy", trig_flag, 0);
        wait_done();
        chk(first_rd == 16'hF800, "R2", "first read address", first_rd, 16'hF800);
        check_copy("power-up");
        repeat (20) @(negedge clk);
        chk(rd_cnt == 224 && !busy, "R9", "no second run", rd_cnt, 224);
        chk(bus_hold == 1'b0, "R7", "bus released after power-up", bus_hold, 0);
    endtask

    task automatic t_bad_writes();
        prep(8'h3C, 1);
        ctl_write(8'hD8, 8'hFE);
        ctl_write(8'hD7, 8'h01);
        ctl_write(8'h58, 8'h01);
        repeat (10) @(negedge clk);
        chk(trig_flag == 1'b0, "R10", "flag after ignored writes", trig_flag, 0);
        chk(rd_cnt == 0 && !busy, "R10", "no download after ignored writes", rd_cnt, 0);
    endtask

    task automatic t_sw_trigger(input logic [7:0] s, input int l);
        prep(s, l);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_addr = 8'hD8; ctl_wdata = 8'h01;
        @(negedge clk);
        ctl_wr = 1'b0;
        chk(trig_flag && busy, "R8", "flag and busy after trigger", {trig_flag, busy}, 3);
        wait_done();
        check_copy("software");
        chk(trig_flag == 1'b0, "R8", "flag self-cleared", trig_flag, 0);
        chk(bus_hold == 1'b0, "R7", "bus released after software run", bus_hold, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) rf_mem[i] = 8'hEE;
        t_reset();
        t_powerup();
        t_bad_writes();
        t_sw_trigger(8'hA5, 0);
        t_sw_trigger(8'h5A, 3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        total++; bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule